// File: doc/BRIEF.md
# Dual-Output Prioritised Interrupt Controller

This block collects level-sensitive interrupt requests from 96 sources, held in three banks of 32, and sends each one to one of two processor lines: a fast line (`fiq_o`) or a normal line (`irq_o`). Each source has a mask bit and a software-request bit. Each source also has a per-source level register that picks its line and holds a 6-bit priority. For each line the block forms the vector of unmasked pending requests. It then names the winning source, which is the one with the smallest priority value, with the lower index winning a tie.

Software reaches the block through a plain 32-bit register port with a byte address. A write takes effect at the clock edge where `wr_en_i` is high. A read returns its data on `rdata_o` one edge after `rd_en_i`. An interrupt handler reads the active-source register for its line to learn which source to serve. It clears a software request through the write-one clear register of the matching bank. A priority threshold can hold both lines low unless the winning priority is below it.

Top module: `intc_dual_route`

## Requirements
- R1: After synchronous reset every mask bit is 1, every software-request bit is 0, every level register is 0, the threshold (byte offset 0x68, bits [7:0]) is 0xFF, and `irq_o` and `fiq_o` are 0.
- R2: Bank n (n = 0..2, base 0x80 + 0x20·n) holds its mask at +0x04, which can be read and written. A write to +0x08 clears every mask bit written as 1. A write to +0x0C sets every mask bit written as 1. Bits written as 0 are left alone, and reads of +0x08 and +0x0C return zero.
- R3: The software-request word of bank n is set bit by bit through +0x10, which also reads it back. It is cleared bit by bit through +0x14, which reads zero. The request of source 32n+b is raw input b of bank n OR software bit b.
- R4: A read of bank n offset +0x00 returns the raw inputs `src_i[32n+31:32n]`.
- R5: A read of bank n offset +0x18 returns request AND NOT mask AND NOT route. A read of +0x1C returns request AND NOT mask AND route.
- R6: The level register of source i is at 0x100 + 4·i. Bit 0 is the route (1 = fast line), bits [7:2] hold the priority, and every other bit reads as 0.
- R7: The active-source reads, at 0x40 for the normal line and 0x44 for the fast line in bits [6:0], give the pending source with the smallest priority value. On a tie the lower index wins.
- R8: When nothing is pending on a line, its active-source read returns 0x7F.
- R9: The priority reads, at 0x60 for the normal line and 0x64 for the fast line in bits [5:0], give the winner's priority, or 0 when nothing is pending.
- R10: A line output is 1 when its line has a winner and either the threshold is 0xFF or the winner's priority is below the threshold.
- R11: A line output shows a register write or an input change one clock edge after that write's edge or after the edge that samples the change.
- R12: A read and a write in the same cycle to the same address return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 96 | Level-sensitive interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one edge after `rd_en_i` |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
Two functions can meet in one cycle: a register read and a register write to the same word. The bench provokes this by raising both strobes on the mask word of bank 0 in one cycle. It judges the result by requiring the old word on `rdata_o` and the new word on the read that follows. The bench also steps one cycle at a time across a mask-clear write that uncovers a pending source. This shows `irq_o` still low one edge later and high the edge after that. The same check is made around threshold changes, where the line drops or rises only after the edge that follows the threshold write.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ID_W = 7;
  localparam logic [ID_W-1:0] SPURIOUS_ID = '1;

  // word offsets inside one bank window
  typedef enum logic [2:0] {
    SUB_RAW  = 3'd0,
    SUB_MASK = 3'd1,
    SUB_MCLR = 3'd2,
    SUB_MSET = 3'd3,
    SUB_SSET = 3'd4,
    SUB_SCLR = 3'd5,
    SUB_PIRQ = 3'd6,
    SUB_PFIQ = 3'd7
  } bank_sub_e;

  localparam int OFS_ACT_IRQ  = 'h040;
  localparam int OFS_ACT_FIQ  = 'h044;
  localparam int OFS_PRI_IRQ  = 'h060;
  localparam int OFS_PRI_FIQ  = 'h064;
  localparam int OFS_THRESH   = 'h068;
  localparam int OFS_BANK0    = 'h080;
  localparam int BANK_STRIDE  = 'h020;
  localparam int OFS_LEVEL0   = 'h100;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N      = 96,
  parameter int PRIO_W = 6,
  parameter int ID_W   = intc_pkg::ID_W
) (
  input  logic [N-1:0]        pend_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                vld_o,
  output logic [ID_W-1:0]     id_o,
  output logic [PRIO_W-1:0]   prio_o
);
  // linear scan: strict less-than keeps the lower index on a tie
  always_comb begin
    vld_o  = 1'b0;
    id_o   = intc_pkg::SPURIOUS_ID;
    prio_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && (!vld_o || (prio_i[i*PRIO_W +: PRIO_W] < prio_o))) begin
        vld_o  = 1'b1;
        id_o   = ID_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] route_i,
  input  logic [W-1:0] wdata_i,
  input  logic         mask_we_i,
  input  logic         mask_set_i,
  input  logic         mask_clr_i,
  input  logic         swi_set_i,
  input  logic         swi_clr_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] swi_o,
  output logic [W-1:0] pend_irq_o,
  output logic [W-1:0] pend_fiq_o
);
  logic [W-1:0] mask_q, swi_q, req;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      swi_q  <= '0;
    end else begin
      if (mask_we_i)       mask_q <= wdata_i;
      else if (mask_set_i) mask_q <= mask_q | wdata_i;
      else if (mask_clr_i) mask_q <= mask_q & ~wdata_i;
      if (swi_set_i)       swi_q  <= swi_q | wdata_i;
      else if (swi_clr_i)  swi_q  <= swi_q & ~wdata_i;
    end
  end

  assign req        = src_i | swi_q;
  assign pend_irq_o = req & ~mask_q & ~route_i;
  assign pend_fiq_o = req & ~mask_q & route_i;
  assign mask_o     = mask_q;
  assign swi_o      = swi_q;

  AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    mask_set_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));  // R2
  AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    mask_clr_i |=> ((mask_q & $past(wdata_i)) == '0));  // R2
  AST_SWI_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    swi_set_i |=> ((swi_q & $past(wdata_i)) == $past(wdata_i)));  // R3
  AST_SWI_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    swi_clr_i |=> ((swi_q & $past(wdata_i)) == '0));  // R3
endmodule

// File: rtl/intc_dual_route.sv
module intc_dual_route #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int PRIO_W    = 6,
  parameter int THR_W     = 8,
  parameter int ADDR_W    = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic                        wr_en_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BANK_W-1:0]           wdata_i,
  output logic [BANK_W-1:0]           rdata_o,
  output logic                        irq_o,
  output logic                        fiq_o
);
  import intc_pkg::*;

  localparam int NSRC   = NUM_BANKS * BANK_W;
  localparam int DW     = BANK_W;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] A_ACT_IRQ = ADDR_W'(OFS_ACT_IRQ);
  localparam logic [ADDR_W-1:0] A_ACT_FIQ = ADDR_W'(OFS_ACT_FIQ);
  localparam logic [ADDR_W-1:0] A_PRI_IRQ = ADDR_W'(OFS_PRI_IRQ);
  localparam logic [ADDR_W-1:0] A_PRI_FIQ = ADDR_W'(OFS_PRI_FIQ);
  localparam logic [ADDR_W-1:0] A_THRESH  = ADDR_W'(OFS_THRESH);
  localparam logic [ADDR_W-1:0] A_BANK0   = ADDR_W'(OFS_BANK0);
  localparam logic [ADDR_W-1:0] A_BANKEND = ADDR_W'(OFS_BANK0 + NUM_BANKS*BANK_STRIDE);
  localparam logic [WORD_W-1:0] W_LVL0    = WORD_W'(OFS_LEVEL0 / 4);
  localparam logic [WORD_W-1:0] W_LVLEND  = WORD_W'(OFS_LEVEL0 / 4 + NSRC);

  // ---------------- address decode ----------------
  logic [ADDR_W-1:0] boff;
  logic              bank_hit;
  logic [ADDR_W-6:0] bsel;
  bank_sub_e         bsub;
  logic [WORD_W-1:0] word, lvl_off;
  logic              lvl_hit;

  assign boff     = addr_i - A_BANK0;
  assign bank_hit = (addr_i >= A_BANK0) && (addr_i < A_BANKEND);
  assign bsel     = boff[ADDR_W-1:5];
  assign bsub     = bank_sub_e'(boff[4:2]);
  assign word     = addr_i[ADDR_W-1:2];
  assign lvl_hit  = (word >= W_LVL0) && (word < W_LVLEND);
  assign lvl_off  = word - W_LVL0;

  // ---------------- level registers ----------------
  logic [NSRC-1:0]        route_q;
  logic [NSRC*PRIO_W-1:0] prio_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= '0;
      prio_q  <= '0;
    end else if (wr_en_i && lvl_hit) begin
      route_q[lvl_off]               <= wdata_i[0];
      prio_q[lvl_off*PRIO_W +: PRIO_W] <= wdata_i[2 +: PRIO_W];
    end
  end

  // ---------------- threshold ----------------
  logic [THR_W-1:0] thr_q;
  always_ff @(posedge clk) begin
    if (rst)                              thr_q <= '1;
    else if (wr_en_i && addr_i == A_THRESH) thr_q <= wdata_i[THR_W-1:0];
  end

  // ---------------- banks ----------------
  logic [NSRC-1:0] mask_all, swi_all, pirq_all, pfiq_all;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = wr_en_i && bank_hit && (bsel == (ADDR_W-5)'(g));
    intc_bank #(.W(BANK_W)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .src_i      (src_i[g*BANK_W +: BANK_W]),
      .route_i    (route_q[g*BANK_W +: BANK_W]),
      .wdata_i    (wdata_i),
      .mask_we_i  (sel && bsub == SUB_MASK),
      .mask_set_i (sel && bsub == SUB_MSET),
      .mask_clr_i (sel && bsub == SUB_MCLR),
      .swi_set_i  (sel && bsub == SUB_SSET),
      .swi_clr_i  (sel && bsub == SUB_SCLR),
      .mask_o     (mask_all[g*BANK_W +: BANK_W]),
      .swi_o      (swi_all[g*BANK_W +: BANK_W]),
      .pend_irq_o (pirq_all[g*BANK_W +: BANK_W]),
      .pend_fiq_o (pfiq_all[g*BANK_W +: BANK_W])
    );
  end

  // ---------------- arbitration, one per line ----------------
  logic              irq_vld, fiq_vld;
  logic [ID_W-1:0]   irq_id, fiq_id;
  logic [PRIO_W-1:0] irq_pri, fiq_pri;

  intc_arbiter #(.N(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb_irq (
    .pend_i (pirq_all), .prio_i (prio_q),
    .vld_o (irq_vld), .id_o (irq_id), .prio_o (irq_pri));

  intc_arbiter #(.N(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb_fiq (
    .pend_i (pfiq_all), .prio_i (prio_q),
    .vld_o (fiq_vld), .id_o (fiq_id), .prio_o (fiq_pri));

  // ---------------- registered line outputs ----------------
  logic thr_off, irq_pass, fiq_pass;
  assign thr_off  = (thr_q == '1);
  assign irq_pass = thr_off || (THR_W'(irq_pri) < thr_q);
  assign fiq_pass = thr_off || (THR_W'(fiq_pri) < thr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_vld && irq_pass;
      fiq_o <= fiq_vld && fiq_pass;
    end
  end

  // ---------------- read path ----------------
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bank_hit) begin
      unique case (bsub)
        SUB_RAW:  rd_mux = src_i[bsel*BANK_W +: BANK_W];
        SUB_MASK: rd_mux = mask_all[bsel*BANK_W +: BANK_W];
        SUB_SSET: rd_mux = swi_all[bsel*BANK_W +: BANK_W];
        SUB_PIRQ: rd_mux = pirq_all[bsel*BANK_W +: BANK_W];
        SUB_PFIQ: rd_mux = pfiq_all[bsel*BANK_W +: BANK_W];
        default:  rd_mux = '0;
      endcase
    end else if (lvl_hit) begin
      rd_mux = DW'({prio_q[lvl_off*PRIO_W +: PRIO_W], 1'b0, route_q[lvl_off]});
    end else begin
      unique case (addr_i)
        A_ACT_IRQ: rd_mux = DW'(irq_id);
        A_ACT_FIQ: rd_mux = DW'(fiq_id);
        A_PRI_IRQ: rd_mux = DW'(irq_pri);
        A_PRI_FIQ: rd_mux = DW'(fiq_pri);
        A_THRESH:  rd_mux = DW'(thr_q);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  // ---------------- assertions ----------------
  AST_RESET_THRESH: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (thr_q == '1 && !irq_o && !fiq_o));  // R1
  AST_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (pirq_all == '0) |-> (irq_id == SPURIOUS_ID));  // R8
  AST_SPURIOUS_FIQ: assert property (@(posedge clk) disable iff (rst)
    (pfiq_all == '0) |-> (fiq_id == SPURIOUS_ID && fiq_pri == '0));  // R9
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_vld |-> pirq_all[irq_id]);  // R7
  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    (pirq_all == '0 && pfiq_all == '0) |=> (!irq_o && !fiq_o));  // R10
endmodule

// File: tb/intc_dual_route_bench.sv
`timescale 1ns/1ps
module intc_dual_route_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  intc_dual_route u_intc_dual_route (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(10'h084, v); chk("R1 mask bank0", v, 32'hFFFF_FFFF);
    rd(10'h0C4, v); chk("R1 mask bank2", v, 32'hFFFF_FFFF);
    rd(10'h0B0, v); chk("R1 swi bank1", v, 32'h0);
    rd(10'h068, v); chk("R1 threshold", v, 32'hFF);
    rd(10'h114, v); chk("R1 level 5", v, 32'h0);
    chk("R1 lines low", {30'h0, irq, fiq}, 32'h0);
    rd(10'h040, v); chk("R8 spurious irq at reset", v, 32'h7F);
  endtask

  task automatic t_raw();
    logic [31:0] v;
    src[63:32] = 32'hDEAD_BEEF;
    rd(10'h0A0, v); chk("R4 raw bank1", v, 32'hDEAD_BEEF);
    rd(10'h080, v); chk("R4 raw bank0", v, 32'h0);
    src = '0;
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(10'h088, 32'h0000_00F0);
    rd(10'h084, v); chk("R2 mask clear", v, 32'hFFFF_FF0F);
    wr(10'h08C, 32'h0000_0010);
    rd(10'h084, v); chk("R2 mask set", v, 32'hFFFF_FF1F);
    rd(10'h088, v); chk("R2 clear reads zero", v, 32'h0);
    rd(10'h08C, v); chk("R2 set reads zero", v, 32'h0);
    wr(10'h0A4, 32'h1234_5678);
    rd(10'h0A4, v); chk("R2 direct mask write", v, 32'h1234_5678);
    wr(10'h08C, 32'hFFFF_FFFF);
    wr(10'h0A4, 32'hFFFF_FFFF);
  endtask

  task automatic t_swi();
    logic [31:0] v;
    wr(10'h0D0, 32'h5);
    rd(10'h0D0, v); chk("R3 swi set", v, 32'h5);
    wr(10'h0D4, 32'h1);
    rd(10'h0D0, v); chk("R3 swi single clear", v, 32'h4);
    rd(10'h0D4, v); chk("R3 swi clear reads zero", v, 32'h0);
    wr(10'h0D4, 32'hFFFF_FFFF);
    rd(10'h0D0, v); chk("R3 swi clear all", v, 32'h0);
  endtask

  task automatic t_pend();
    logic [31:0] v;
    src[1:0] = 2'b11;
    wr(10'h104, 32'h1);
    wr(10'h088, 32'h3);
    rd(10'h098, v); chk("R5 pending irq", v, 32'h1);
    rd(10'h09C, v); chk("R5 pending fiq", v, 32'h2);
    rd(10'h040, v); chk("R7 active irq src0", v, 32'h0);
    rd(10'h044, v); chk("R7 active fiq src1", v, 32'h1);
    src = '0;
    wr(10'h08C, 32'hFFFF_FFFF);
    wr(10'h104, 32'h0);
    rd(10'h098, v); chk("R5 pending cleared by mask", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(10'h27C, 32'hFFFF_FFFF);
    rd(10'h27C, v); chk("R6 level 95 fields", v, 32'hFD);
    wr(10'h27C, 32'h0);
  endtask

  task automatic t_arb();
    logic [31:0] v;
    wr(10'h1A0, 32'h0C);       // src 40 prio 3
    wr(10'h218, 32'h0C);       // src 70 prio 3
    wr(10'h128, 32'h14);       // src 10 prio 5
    wr(10'h090, 32'h400);      // swi src 10
    wr(10'h0B0, 32'h100);      // swi src 40
    wr(10'h0D0, 32'h40);       // swi src 70
    wr(10'h088, 32'h400);
    wr(10'h0A8, 32'h100);
    wr(10'h0C8, 32'h40);
    rd(10'h040, v); chk("R7 tie to lower index", v, 32'd40);
    rd(10'h060, v); chk("R9 irq winner prio", v, 32'd3);
    chk("R10 irq line open threshold", {31'h0, irq}, 32'h1);
    wr(10'h068, 32'h3); tick();
    chk("R10 threshold equal blocks", {31'h0, irq}, 32'h0);
    wr(10'h068, 32'h4); tick();
    chk("R10 threshold above passes", {31'h0, irq}, 32'h1);
    wr(10'h068, 32'hFF);
    wr(10'h218, 32'h0D);       // src 70 to fast line
    rd(10'h044, v); chk("R7 fiq winner", v, 32'd70);
    rd(10'h064, v); chk("R9 fiq winner prio", v, 32'd3);
    chk("R10 fiq line", {31'h0, fiq}, 32'h1);
    wr(10'h1A0, 32'h18);       // src 40 prio 6
    rd(10'h040, v); chk("R7 lower prio value wins", v, 32'd10);
    wr(10'h08C, 32'hFFFF_FFFF);
    wr(10'h0AC, 32'hFFFF_FFFF);
    wr(10'h0CC, 32'hFFFF_FFFF);
    rd(10'h040, v); chk("R8 spurious irq", v, 32'h7F);
    rd(10'h044, v); chk("R8 spurious fiq", v, 32'h7F);
    rd(10'h060, v); chk("R9 prio when idle", v, 32'h0);
    chk("R10 lines low when masked", {30'h0, irq, fiq}, 32'h0);
  endtask

  task automatic t_timing();
    // swi src 10 is still set; unmask it and watch the edge count
    @(negedge clk);
    addr = 10'h088; wdata = 32'h400; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 line not yet up", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R11 line up next edge", {31'h0, irq}, 32'h1);
    wr(10'h08C, 32'hFFFF_FFFF);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(10'h084, 32'hFFFF_FFFF);
    @(negedge clk);
    addr = 10'h084; wdata = 32'hA5A5_A5A5; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 read sees old value", rdata, 32'hFFFF_FFFF);
    rd(10'h084, v); chk("R12 write landed", v, 32'hA5A5_A5A5);
    wr(10'h084, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_raw();
    t_mask();
    t_swi();
    t_pend();
    t_level();
    t_arb();
    t_timing();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule